// File: doc/BRIEF.md
# Halfword Instruction Fetch Aligner

This block sits between a fetch bus that returns naturally aligned 32-bit words and the decode stage of a core whose instruction stream mixes 16-bit and 32-bit encodings on halfword boundaries. It issues word fetches and keeps up to three halfwords in a small queue. Each cycle it takes the oldest halfword, works out the instruction length from its two lowest bits, and gives decode one whole instruction along with that instruction's address.

On the fetch side a request is taken when `req_valid_o` and `req_ready_i` are both high. The bus returns the data word on `resp_data_i` exactly one cycle after it takes the request, and it stalls only by holding `req_ready_i` low. A redirect from the execute stage may name any halfword address. It flushes the queue, drops any response still owed to the old path, and starts fetching at once from the word that holds the target. Decode stalls with `dec_ready_i`, and the offered instruction is held until it is taken.

A 32-bit instruction whose halves lie in two different bus words is joined from the end of one word and the start of the next. In sequential flow this adds no cycle. After a redirect it adds one cycle.

Top module: `fetch_aligner`

## Requirements
- R1: During and right after reset, `dec_valid_o` is 0, `req_valid_o` is 1 and `req_addr_o` equals the word-aligned reset address (parameter `RESET_PC`). `dec_pc_o` equals that same address.
- R2: A halfword whose bits [1:0] are 2'b11 starts a 32-bit instruction, and any other value starts a 16-bit instruction. A 16-bit instruction appears on `dec_instr_o[15:0]`, and bits [31:16] are zero.
- R3: Instructions come out in address order with the lower halfword in bits [15:0]. Each accepted instruction moves `dec_pc_o` forward by 2 (16-bit) or 4 (32-bit).
- R4: With the bus and decode always ready, `dec_valid_o` stays high on every cycle after the first valid cycle that follows a redirect, including cycles where a 32-bit instruction crosses a word boundary.
- R5: After a redirect in cycle t, a 32-bit target on a word boundary or any 16-bit target is offered in cycle t+1, given a ready bus and decode.
- R6: After a redirect in cycle t, a 32-bit target at an address with bit 1 set is first offered in cycle t+2.
- R7: In the redirect cycle `dec_valid_o` is 0. Every buffered halfword and any response owed to a request taken before the redirect is discarded, and `dec_pc_o` equals the target in the next cycle.
- R8: When the target has bit 1 set, the lower halfword of the first word returned for it is dropped, and the first instruction offered is the halfword at the target.
- R9: While `req_ready_i` is low and no redirect occurs, `req_valid_o` stays high and `req_addr_o` stays unchanged. No halfword is lost or repeated.
- R10: While `dec_valid_o` is high and `dec_ready_i` is low, the offered instruction and its address stay unchanged in the next cycle unless a redirect occurs.
- R11: No more than three halfwords are ever held. Outside a redirect, a request is raised only when at most one halfword will be held after this cycle's handoff.
- R12: Request addresses are word aligned, and each taken request without a redirect is followed by the next word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Jump or branch taken this cycle |
| redirect_pc_i | input | 31 | Target address bits [31:1] (halfword address) |
| req_valid_o | output | 1 | Word fetch request |
| req_addr_o | output | 32 | Word-aligned fetch address |
| req_ready_i | input | 1 | Bus takes the request this cycle |
| resp_data_i | input | 32 | Fetched word, valid the cycle after a taken request |
| dec_valid_o | output | 1 | Complete instruction offered to decode |
| dec_instr_o | output | 32 | Instruction bits, zero-extended when 16-bit |
| dec_pc_o | output | 32 | Address of the offered instruction |
| dec_ready_i | input | 1 | Decode takes the offered instruction |

## Verification
The bench targets redirects to each kind of target. A design that skipped the dropped lower halfword would offer the wrong instruction first. One that waited for a second word on every unaligned target would add a cycle to 16-bit targets. One that let an old-path response into the queue would release a stale instruction after the jump. Long fetch stalls, decode stalls and redirects landing on a stalled request are mixed with streams that cross word boundaries. These catch halfwords that are lost or duplicated when the queue is nearly full, and straddling instructions that wrongly cost a bubble in sequential flow.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned HALF_W = 16;
  typedef logic [HALF_W-1:0] half_t;
  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_HALF = 2'd1,
    TAKE_WORD = 2'd2
  } take_e;
endpackage

// File: rtl/fa_len_dec.sv
module fa_len_dec
  import fa_pkg::*;
#(
  parameter int unsigned NW = 3
) (
  input  half_t [1:0]           head_i,
  input  logic  [NW-1:0]        avail_i,
  output logic                  ready_o,
  output take_e                 take_o,
  output logic  [2*HALF_W-1:0]  instr_o
);
  logic is32;

  assign is32    = (head_i[0][1:0] == 2'b11);
  assign ready_o = is32 ? (avail_i >= NW'(2)) : (avail_i != '0);
  assign take_o  = is32 ? TAKE_WORD : TAKE_HALF;
  assign instr_o = is32 ? {head_i[1], head_i[0]} : {{HALF_W{1'b0}}, head_i[0]};
endmodule

// File: rtl/fa_hw_queue.sv
module fa_hw_queue
  import fa_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned AVN  = DEPTH + 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NW   = $clog2(AVN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 resp_valid_i,
  input  logic                 resp_drop_lo_i,
  input  logic [2*HALF_W-1:0]  resp_data_i,
  input  take_e                take_i,
  output half_t [1:0]          head_o,
  output logic [NW-1:0]        avail_o,
  output logic [NW-1:0]        left_o
);
  half_t [DEPTH-1:0] buf_q, buf_d;
  logic  [CW-1:0]    cnt_q;
  half_t [AVN-1:0]   av;
  logic  [NW-1:0]    n_new, base;
  logic  [1:0]       tk;

  assign tk = take_i;

  // merged view: held halfwords first, then this cycle's response halves
  always_comb begin
    av    = '0;
    base  = NW'(cnt_q);
    n_new = !resp_valid_i ? NW'(0) : (resp_drop_lo_i ? NW'(1) : NW'(2));
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_q)) av[i] = buf_q[i];
    end
    if (resp_valid_i) begin
      if (resp_drop_lo_i) begin
        av[base] = resp_data_i[2*HALF_W-1:HALF_W];
      end else begin
        av[base]         = resp_data_i[HALF_W-1:0];
        av[base+NW'(1)]  = resp_data_i[2*HALF_W-1:HALF_W];
      end
    end
  end

  assign avail_o = base + n_new;
  assign left_o  = avail_o - NW'(tk);
  assign head_o  = {av[1], av[0]};

  always_comb begin
    for (int j = 0; j < DEPTH; j++) buf_d[j] = av[j + int'(tk)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      buf_q <= buf_d;
      cnt_q <= flush_i ? '0 : left_o[CW-1:0];
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (left_o <= NW'(DEPTH)));
endmodule

// File: rtl/fa_fetch_ctrl.sv
module fa_fetch_ctrl #(
  parameter int unsigned         XLEN     = 32,
  parameter logic [XLEN-1:0]     RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redirect_i,
  input  logic [XLEN-1:1]  redirect_pc_i,
  input  logic             room_i,
  input  logic             req_ready_i,
  output logic             req_valid_o,
  output logic [XLEN-1:0]  req_addr_o,
  output logic             resp_valid_o,
  output logic             drop_lo_o
);
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

  logic [XLEN-1:0] fetch_q, tgt_word;
  logic            inflight_q, drop_q, accept;

  assign tgt_word     = {redirect_pc_i[XLEN-1:2], 2'b00};
  assign req_valid_o  = redirect_i | room_i;
  assign req_addr_o   = redirect_i ? tgt_word : fetch_q;
  assign accept       = req_valid_o & req_ready_i;
  assign resp_valid_o = inflight_q & ~redirect_i;
  assign drop_lo_o    = drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q    <= {RESET_PC[XLEN-1:2], 2'b00};
      inflight_q <= 1'b0;
      drop_q     <= 1'b0;
    end else if (redirect_i) begin
      fetch_q    <= accept ? tgt_word + WORD_STEP : tgt_word;
      inflight_q <= accept;
      drop_q     <= redirect_pc_i[1];
    end else begin
      if (accept) fetch_q <= fetch_q + WORD_STEP;
      inflight_q <= accept;
      if (inflight_q) drop_q <= 1'b0;
    end
  end

  a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !redirect_i |=>
      redirect_i || (req_valid_o && $stable(req_addr_o)));

  a_r12_next_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && !redirect_i |=>
      redirect_i || !req_valid_o || (req_addr_o == $past(req_addr_o) + WORD_STEP));
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int unsigned      XLEN     = 32,
  parameter int unsigned      DEPTH    = 3,
  parameter logic [XLEN-1:0]  RESET_PC = 32'h0000_0100,
  localparam int unsigned     NW       = $clog2(DEPTH + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redirect_i,
  input  logic [XLEN-1:1]  redirect_pc_i,
  output logic             req_valid_o,
  output logic [XLEN-1:0]  req_addr_o,
  input  logic             req_ready_i,
  input  logic [31:0]      resp_data_i,
  output logic             dec_valid_o,
  output logic [31:0]      dec_instr_o,
  output logic [XLEN-1:0]  dec_pc_o,
  input  logic             dec_ready_i
);
  half_t [1:0]     head;
  logic [NW-1:0]   avail, left;
  logic            len_ready, fire, room, resp_valid, drop_lo;
  take_e           len_take, q_take;
  logic [XLEN-1:0] pc_q;

  assign dec_valid_o = len_ready & ~redirect_i;
  assign fire        = dec_valid_o & dec_ready_i;
  assign q_take      = fire ? len_take : TAKE_NONE;
  // request only if a full word still fits after this cycle's handoff
  assign room        = (left <= NW'(DEPTH - 2));
  assign dec_pc_o    = pc_q;

  fa_fetch_ctrl #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_fetch (
    .clk_i, .rst_ni,
    .redirect_i, .redirect_pc_i,
    .room_i       (room),
    .req_ready_i,
    .req_valid_o, .req_addr_o,
    .resp_valid_o (resp_valid),
    .drop_lo_o    (drop_lo)
  );

  fa_hw_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .flush_i        (redirect_i),
    .resp_valid_i   (resp_valid),
    .resp_drop_lo_i (drop_lo),
    .resp_data_i    (resp_data_i),
    .take_i         (q_take),
    .head_o         (head),
    .avail_o        (avail),
    .left_o         (left)
  );

  fa_len_dec #(.NW(NW)) u_len (
    .head_i  (head),
    .avail_i (avail),
    .ready_o (len_ready),
    .take_o  (len_take),
    .instr_o (dec_instr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= {RESET_PC[XLEN-1:2], 2'b00};
    else if (redirect_i) pc_q <= {redirect_pc_i, 1'b0};
    else if (fire)       pc_q <= pc_q + ((len_take == TAKE_WORD) ? XLEN'(4) : XLEN'(2));
  end

  a_r7_pc_to_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> dec_pc_o == $past({redirect_pc_i, 1'b0}));

  a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_ready_i |=> redirect_i ||
      (dec_pc_o == $past(dec_pc_o) + (($past(dec_instr_o[1:0]) == 2'b11) ? XLEN'(4) : XLEN'(2))));

  a_r10_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !dec_ready_i |=> redirect_i ||
      (dec_valid_o && $stable(dec_instr_o) && $stable(dec_pc_o)));
endmodule

// File: tb/tb_fetch_aligner.sv
module tb_fetch_aligner;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [31:1] redirect_pc = '0;
  logic        req_ready = 1'b0;
  logic [31:0] resp_data = '0;
  logic        dec_ready = 1'b0;
  logic        req_valid, dec_valid;
  logic [31:0] req_addr, dec_instr, dec_pc;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_aligner #(.RESET_PC(RST_PC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .redirect_i(redirect), .redirect_pc_i(redirect_pc),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_ready_i(req_ready),
    .resp_data_i(resp_data),
    .dec_valid_o(dec_valid), .dec_instr_o(dec_instr), .dec_pc_o(dec_pc),
    .dec_ready_i(dec_ready)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] x;
    x = a ^ 32'h5bd1_e995;
    x = x * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [15:0] mem_half(input logic [31:0] a);
    logic [31:0] w;
    w = mem_word({a[31:2], 2'b00});
    return a[1] ? w[31:16] : w[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [15:0] mq[$];
  logic [31:0] m_pc = RST_PC, m_faddr = RST_PC, m_iaddr = '0;
  bit          m_infl = 0, m_drop = 0;
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  string       tag = "R3";
  logic        obs_valid, obs_rv;
  logic [31:0] obs_instr, obs_pc, obs_ra;

  task automatic cycle(input bit rd, input logic [31:0] tgt, input bit rr, input bit dr);
    logic [15:0] av[$];
    logic [31:0] w, e_instr, e_ra;
    bit e_is32, e_valid, e_rv, acc;
    int e_take;
    redirect    = rd;
    redirect_pc = tgt[31:1];
    req_ready   = rr;
    dec_ready   = dr;
    resp_data   = pend ? mem_word(pend_addr) : 32'hDEAD_BEEF;
    #1;
    av = mq;
    if (m_infl && !rd) begin
      w = mem_word(m_iaddr);
      if (!m_drop) av.push_back(w[15:0]);
      av.push_back(w[31:16]);
    end
    e_is32  = (av.size() > 0) && (av[0][1:0] == 2'b11);
    e_valid = !rd && (av.size() > 0) && (!e_is32 || av.size() > 1);
    e_instr = !e_valid ? 32'h0 : (e_is32 ? {av[1], av[0]} : {16'h0, av[0]});
    e_take  = (e_valid && dr) ? (e_is32 ? 2 : 1) : 0;
    e_rv    = rd || ((av.size() - e_take) <= 1);
    e_ra    = rd ? {tgt[31:2], 2'b00} : m_faddr;
    obs_valid = dec_valid; obs_instr = dec_instr; obs_pc = dec_pc;
    obs_rv = req_valid; obs_ra = req_addr;
    check(dec_valid === e_valid, tag, "dec_valid", 32'(dec_valid), 32'(e_valid));
    if (e_valid) begin
      check(dec_instr === e_instr, tag, "dec_instr", dec_instr, e_instr);
      check(dec_pc === m_pc, tag, "dec_pc", dec_pc, m_pc);
    end
    check(req_valid === e_rv, tag, "req_valid (R11)", 32'(req_valid), 32'(e_rv));
    if (e_rv) check(req_addr === e_ra, tag, "req_addr (R12)", req_addr, e_ra);
    acc = e_rv && rr;
    if (rd) begin
      mq.delete();
      m_pc    = {tgt[31:1], 1'b0};
      m_drop  = tgt[1];
      m_iaddr = {tgt[31:2], 2'b00};
      m_faddr = m_iaddr + (acc ? 32'd4 : 32'd0);
      m_infl  = acc;
    end else begin
      mq = av;
      for (int k = 0; k < e_take; k++) void'(mq.pop_front());
      if (e_take != 0) m_pc = m_pc + (e_is32 ? 32'd4 : 32'd2);
      if (m_infl) m_drop = 0;
      if (acc) begin
        m_iaddr = m_faddr;
        m_faddr = m_faddr + 32'd4;
      end
      m_infl = acc;
    end
    pend      = req_valid && req_ready;
    pend_addr = req_addr;
    @(negedge clk);
  endtask

  function automatic logic [31:0] find_target(input logic [31:0] from, input bit odd, input bit is32);
    for (logic [31:0] a = from; a < from + 32'h4000; a += 4) begin
      logic [31:0] t;
      t = odd ? a + 2 : a;
      if ((mem_half(t)[1:0] == 2'b11) == is32) return t;
    end
    return from;
  endfunction

  task automatic latency(input string t, input logic [31:0] tgt, input int exp_lat);
    int lat;
    lat = 0;
    tag = t;
    cycle(1, tgt, 1, 1);
    for (int k = 1; k <= 4; k++) begin
      cycle(0, 0, 1, 1);
      if (lat == 0 && obs_valid) begin
        lat = k;
        check(obs_pc === tgt, t, "first pc after redirect (R7/R8)", obs_pc, tgt);
      end
    end
    check(lat == exp_lat, t, "cycles from redirect to first offer", lat, exp_lat);
  endtask

  initial begin
    logic [31:0] t, held_i, held_a;
    int gaps;
    repeat (3) @(negedge clk);
    #1;
    check(dec_valid === 1'b0, "R1", "dec_valid in reset", 32'(dec_valid), 0);
    check(req_valid === 1'b1, "R1", "req_valid in reset", 32'(req_valid), 1);
    check(req_addr === RST_PC, "R1", "req_addr in reset", req_addr, RST_PC);
    check(dec_pc === RST_PC, "R1", "dec_pc in reset", dec_pc, RST_PC);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    cycle(0, 0, 1, 1);
    tag = "R3";
    repeat (30) cycle(0, 0, 1, 1);

    // R5 / R6 / R8 redirect latencies
    latency("R5", find_target(32'h2000, 0, 1), 1);
    latency("R5", find_target(32'h3000, 1, 0), 1);
    latency("R5", find_target(32'h3800, 0, 0), 1);
    latency("R6", find_target(32'h4000, 1, 1), 2);
    latency("R8", find_target(32'h5000, 1, 1), 2);

    // R4 / R2 continuous flow across word boundaries
    tag = "R4";
    cycle(1, 32'h6000, 1, 1);
    cycle(0, 0, 1, 1);
    gaps = 0;
    for (int k = 0; k < 60; k++) begin
      cycle(0, 0, 1, 1);
      if (!obs_valid) gaps++;
      if (obs_valid && obs_instr[1:0] != 2'b11)
        check(obs_instr[31:16] == 16'h0, "R2", "16-bit upper bits", obs_instr, {16'h0, obs_instr[15:0]});
    end
    check(gaps == 0, "R4", "bubbles in sequential flow", gaps, 0);

    // R10 decode stall
    tag = "R10";
    held_i = obs_instr; held_a = obs_pc;
    cycle(0, 0, 1, 0);
    held_i = obs_instr; held_a = obs_pc;
    for (int k = 0; k < 5; k++) begin
      cycle(0, 0, 1, 0);
      check(obs_valid && obs_instr === held_i && obs_pc === held_a, "R10", "held offer", obs_instr, held_i);
    end
    repeat (10) cycle(0, 0, 1, 1);

    // R9 fetch stall on a redirect target
    tag = "R9";
    t = find_target(32'h7000, 1, 1);
    cycle(1, t, 0, 1);
    for (int k = 0; k < 6; k++) begin
      cycle(0, 0, 0, 1);
      check(obs_rv === 1'b1 && obs_ra === {t[31:2], 2'b00}, "R9", "stalled request", obs_ra, {t[31:2], 2'b00});
    end
    repeat (20) cycle(0, 0, 1, 1);

    // R7 redirect while a response is owed
    tag = "R7";
    cycle(0, 0, 1, 0);
    cycle(1, 32'h8002, 1, 1);
    repeat (10) cycle(0, 0, 1, 1);

    // R11 mixed random traffic
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      bit rd;
      rd = ($urandom % 100) < 4;
      t  = {16'h0001, 15'($urandom), 1'b0};
      cycle(rd, t, ($urandom % 100) < 70, ($urandom % 100) < 75);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule